// File: doc/BRIEF.md
# Dual Data Pointer with Auto-Step

This block holds two 16-bit address pointers for external data accesses: a main pointer and a shadow pointer. A small control register chooses which one is live. The live pointer drives the external-data address bus continuously. The core reads and writes the live pointer one byte at a time through two byte addresses, and reads or writes the control register at a third address.

Each time the core reports that an external data access has completed, the unit can change the live pointer. Depending on the control register it adds one, subtracts one or leaves the value alone. All arithmetic wraps modulo 65536. It can also swap to the other pointer. With swapping enabled, the pointer that was just used is stepped first, and the selection then flips so that the next access uses the other pointer. Alternating between a source pointer and a destination pointer therefore needs no software work between accesses.

The selection is held in a two-state machine with states PTR_MAIN and PTR_SHADOW. A control-register write moves it to the state named by the select bit. An auto-toggle event, which is a completed access while swapping is enabled, moves it to the other state. In every other cycle it holds its state.

Top module: `ddp_unit`

## Requirements
- R1: After reset both pointers are 0000H, the control register reads 00H (main pointer live, no stepping, no swapping) and `xaddr` is 0000H.
- R2: `xaddr` always equals the live pointer. A write to byte address 0 (bits 7:0) or byte address 1 (bits 15:8) changes only that byte of the live pointer, and a read of either address returns that byte of the live pointer.
- R3: The control register is at byte address 2. Bit 0 selects the pointer (0 = main, 1 = shadow). Bits 2:1 are the step mode. Bit 3 enables swapping. Bits 7:4 read as zero.
- R4: With step mode 01, a completed access (`acc_done` high) adds one to the pointer that was live for that access, wrapping FFFFH to 0000H. The new value is visible from the next cycle.
- R5: With step mode 10, a completed access subtracts one from the pointer that was live, wrapping 0000H to FFFFH.
- R6: With step mode 00 or 11, a completed access leaves both pointers unchanged.
- R7: With bit 3 set, a completed access flips the selection after the step, and control bit 0 reads back the new selection.
- R8: The pointer that is not live is never changed by a step or by a pointer-byte write.
- R9: When a register write and `acc_done` fall in the same cycle, the write takes effect and that access causes neither a step nor a swap.
- R10: Byte address 3 reads as 00H, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Byte address for reads and writes: 0 low byte, 1 high byte, 2 control, 3 unused |
| reg_wr_en | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| acc_done | input | 1 | One-cycle pulse: an external data access using `xaddr` has completed |
| xaddr | output | 16 | External-data address, the live pointer |

## Verification
The bench runs every value of the control register against start values at the wrap boundaries (0000H, FFFFH, 00FFH, 7FFFH) and one ordinary value. It predicts the live address, the control readback and the other pointer arithmetically. A design that wrapped wrongly, or that did not carry into the high byte, would give a wrong address after 00FFH or FFFFH. A design that stepped after the swap would change the pointer that was not used and leave the used one alone. The bench also fires a write and `acc_done` in the same cycle, where a design without a defined priority would step or swap. It writes to the unused byte address, where loose decoding would corrupt the control register.

// File: rtl/ddp_pkg.sv
package ddp_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_RSV  = 2'b11
    } step_mode_t;

    typedef enum logic {
        PTR_MAIN   = 1'b0,
        PTR_SHADOW = 1'b1
    } ptr_sel_t;

    localparam int CTL_SEL_BIT  = 0;
    localparam int CTL_MODE_LSB = 1;
    localparam int CTL_TGL_BIT  = 3;

endpackage

// File: rtl/ddp_ptr_reg.sv
module ddp_ptr_reg #(
    parameter int PW = 16,
    parameter int BW = 8,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [BW-1:0] wr_data,
    input  logic          step_inc,
    input  logic          step_dec,
    output logic [PW-1:0] ptr_o
);

    logic [PW-1:0] ptr_q, ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) begin
            ptr_d[int'(wr_idx)*BW +: BW] = wr_data;
        end else if (step_inc) begin
            ptr_d = ptr_q + PW'(1);
        end else if (step_dec) begin
            ptr_d = ptr_q - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_inc && step_dec)); // R4

endmodule

// File: rtl/ddp_sel_fsm.sv
module ddp_sel_fsm
    import ddp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_wr,
    input  logic     ctl_sel,
    input  logic     toggle,
    output ptr_sel_t sel_o
);

    ptr_sel_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_MAIN: begin
                if (ctl_wr)      state_d = ctl_sel ? PTR_SHADOW : PTR_MAIN;
                else if (toggle) state_d = PTR_SHADOW;
            end
            PTR_SHADOW: begin
                if (ctl_wr)      state_d = ctl_sel ? PTR_SHADOW : PTR_MAIN;
                else if (toggle) state_d = PTR_MAIN;
            end
            default: state_d = PTR_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_MAIN;
        else        state_q <= state_d;
    end

    always_comb begin
        sel_o = state_q;
    end

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !ctl_wr) |=> (state_q != $past(state_q))); // R7

    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (state_q == ptr_sel_t'($past(ctl_sel)))); // R3

endmodule

// File: rtl/ddp_unit.sv
module ddp_unit
    import ddp_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [$clog2(PTR_W/BYTE_W+1)-1:0]      reg_addr,
    input  logic                                   reg_wr_en,
    input  logic [BYTE_W-1:0]                      reg_wdata,
    output logic [BYTE_W-1:0]                      reg_rdata,
    input  logic                                   acc_done,
    output logic [PTR_W-1:0]                       xaddr
);

    localparam int NBYTES = PTR_W / BYTE_W;
    localparam int AW     = $clog2(NBYTES + 1);
    localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int NPTR   = 2;

    step_mode_t     mode_q;
    logic           tgl_q;
    ptr_sel_t       sel;
    logic           sel_bit;
    logic           acc_go;
    logic           ptr_wr;
    logic           ctl_wr;
    logic [PTR_W-1:0] ptr_val [NPTR];

    assign sel_bit = sel;
    assign acc_go  = acc_done && !reg_wr_en;
    assign ptr_wr  = reg_wr_en && (reg_addr < AW'(NBYTES));
    assign ctl_wr  = reg_wr_en && (reg_addr == AW'(NBYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= STEP_NONE;
            tgl_q  <= 1'b0;
        end else if (ctl_wr) begin
            mode_q <= step_mode_t'(reg_wdata[CTL_MODE_LSB +: 2]);
            tgl_q  <= reg_wdata[CTL_TGL_BIT];
        end
    end

    ddp_sel_fsm u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .ctl_sel (reg_wdata[CTL_SEL_BIT]),
        .toggle  (acc_go && tgl_q),
        .sel_o   (sel)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic live;
        assign live = (sel_bit == 1'(g));
        ddp_ptr_reg #(.PW(PTR_W), .BW(BYTE_W), .IW(IW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ptr_wr && live),
            .wr_idx   (reg_addr[IW-1:0]),
            .wr_data  (reg_wdata),
            .step_inc (acc_go && live && (mode_q == STEP_INC)),
            .step_dec (acc_go && live && (mode_q == STEP_DEC)),
            .ptr_o    (ptr_val[g])
        );
    end

    assign xaddr = ptr_val[sel_bit];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < AW'(NBYTES)) begin
            reg_rdata = xaddr[int'(reg_addr[IW-1:0])*BYTE_W +: BYTE_W];
        end else if (reg_addr == AW'(NBYTES)) begin
            reg_rdata[CTL_SEL_BIT]             = sel_bit;
            reg_rdata[CTL_MODE_LSB +: 2]       = mode_q;
            reg_rdata[CTL_TGL_BIT]             = tgl_q;
        end
    end

    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && mode_q == STEP_INC) |=>
            (ptr_val[$past(sel_bit)] == $past(xaddr) + PTR_W'(1))); // R4

    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && mode_q == STEP_DEC) |=>
            (ptr_val[$past(sel_bit)] == $past(xaddr) - PTR_W'(1))); // R5

    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && (mode_q == STEP_NONE || mode_q == STEP_RSV)) |=>
            (ptr_val[$past(sel_bit)] == $past(xaddr))); // R6

    AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ptr_val[~$past(sel_bit)] == $past(ptr_val[~sel_bit]))); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && acc_done) |=> $stable(sel)); // R9

endmodule

// File: tb/tb_ddp_unit.sv
module tb_ddp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        acc_done = 1'b0;
    logic [15:0] xaddr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ddp_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .acc_done  (acc_done),
        .xaddr     (xaddr)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic acc();
        @(negedge clk);
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] vals [5];
        vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'h00FF;
        vals[3] = 16'h7FFF; vals[4] = 16'h1234;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 xaddr", xaddr, 16'h0000);
        rd(2'd2, r);
        chk("R1 control", {8'h00, r}, 16'h0000);
        wr(2'd2, 8'h01);
        chk("R1 shadow", xaddr, 16'h0000);

        for (int vi = 0; vi < 5; vi++) begin
            for (int c = 0; c < 16; c++) begin
                logic [15:0] v, other, act_exp;
                logic s0, tg, s1;
                logic [1:0] md;
                v = vals[vi]; other = ~v;
                s0 = c[0]; md = c[2:1]; tg = c[3];
                wr(2'd2, {7'd0, ~s0});
                wr(2'd0, other[7:0]); wr(2'd1, other[15:8]);
                wr(2'd2, {7'd0, s0});
                wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
                chk("R2 load", xaddr, v);
                wr(2'd2, {4'd0, tg, md, s0});
                acc();
                act_exp = (md == 2'b01) ? v + 16'd1 : (md == 2'b10) ? v - 16'd1 : v;
                s1 = tg ? ~s0 : s0;
                if (md == 2'b01)      chk("R4 inc", (s1 == s0) ? xaddr : act_exp, act_exp);
                else if (md == 2'b10) chk("R5 dec", (s1 == s0) ? xaddr : act_exp, act_exp);
                chk("R7 live after access", xaddr, (s1 == s0) ? act_exp : other);
                rd(2'd2, r);
                chk("R3 R7 control readback", {8'h00, r}, {8'h00, 4'd0, tg, md, s1});
                wr(2'd2, {7'd0, s0});
                chk("R6 used pointer", xaddr, act_exp);
                rd(2'd1, r);
                chk("R2 high byte", {8'h00, r}, {8'h00, act_exp[15:8]});
                rd(2'd0, r);
                chk("R2 low byte", {8'h00, r}, {8'h00, act_exp[7:0]});
                wr(2'd2, {7'd0, ~s0});
                chk("R8 other pointer", xaddr, other);
            end
        end

        // R9: write and access in the same cycle
        wr(2'd2, 8'h0A);
        wr(2'd0, 8'h10); wr(2'd1, 8'h20);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 8'h55; reg_wr_en = 1'b1; acc_done = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; acc_done = 1'b0;
        chk("R9 write wins", xaddr, 16'h2055);
        rd(2'd2, r);
        chk("R9 no swap", {8'h00, r}, 16'h000A);

        // R10: unused address
        wr(2'd3, 8'hFF);
        rd(2'd3, r);
        chk("R10 reads zero", {8'h00, r}, 16'h0000);
        rd(2'd2, r);
        chk("R10 control kept", {8'h00, r}, 16'h000A);
        chk("R10 pointer kept", xaddr, 16'h2055);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule